// File: doc/BRIEF.md
# Dual-Chain Pad Configuration Serializer

This block delivers one configuration word to every pad of a chip. The pads sit on two daisy-chained shift registers. The right chain holds the lower pads, indices 0 up to `N_RIGHT-1`. The left chain holds the upper pads, from `N_RIGHT` up to the top pad. Software controls the block through a single 8-bit control register, and there are two ways to use it:

- **Automatic transfer.** Software writes 1 to the start bit. The engine then walks both chains in parallel, shifting each pad's word out on that chain's data line under one shared serial clock. It finishes with a load pulse so that every pad latches its new word at the same moment.
- **Bit-bang.** While no transfer is running, the remaining register bits drive the enable, reset, load, clock and both data lines directly, so software can sequence the chains by hand.

Pads differ in length. A pad whose bit is set in `HOLD_MASK` sits behind an extra hold-fix stage and takes 12 bits; every other pad takes 13 bits. The stored words come in on a flat vector, `WORD_W` bits per pad, with pad 0 in the lowest bits.

Top module: `padcfg_serializer`

## Requirements
- R1: The read value is {0, data_left, data_right, clock, load, chain_resetn, enable, start}, with start at bit 0 and bit 7 always reading 0, whatever was written to bit 7.
- R2: While `rst_n` is low at a clock edge, the register clears. After that edge, `busy`=0, `ser_en`=0, `ser_load`=0, `ser_clk`=0 and `ser_rstn`=0 (the chains are held in reset).
- R3: When no transfer runs, a write copies bits 1..6 to `ser_en`, `ser_rstn`, `ser_load`, `ser_clk`, `dat_right` and `dat_left`. The outputs change one clock after the write edge.
- R4: A write with bit 0 = 1 while idle starts a transfer. From the next cycle until the transfer ends, `busy`=1, `ser_en`=1 and `ser_rstn`=1.
- R5: A transfer gives exactly max(Lr, Ll) rising edges of `ser_clk`. Here Lr and Ll are the sums of the pad lengths on each chain, a pad being 12 bits if its `HOLD_MASK` bit is 1 and 13 bits otherwise.
- R6: The right chain sends pad `N_RIGHT-1` first, down to pad 0. The left chain sends pad `N_RIGHT` first, up to the top pad. Each word goes out most significant bit first. A 12-bit pad omits bit 12 of its word.
- R7: Once a chain has sent all of its bits, its data line stays 0 for the rest of the shift pulses.
- R8: In automatic mode, the serial clock is high for one system cycle and low for at least one. The data lines hold the same value in the cycle before each rising edge and in the cycle of that edge.
- R9: After the last shift pulse, `ser_load` is high for exactly two system cycles with `ser_clk` low. After that, bit 0 reads 0, `busy` falls, and the lines return to the register values.
- R10: Writes made while `busy`=1 change neither the register bits nor the chain lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| cfg_words | input | (N_RIGHT+N_LEFT)*WORD_W | Stored per-pad words, pad 0 lowest |
| rd_data | output | 8 | Control register read value |
| busy | output | 1 | Automatic transfer running |
| ser_en | output | 1 | Chain enable |
| ser_rstn | output | 1 | Chain reset, active low |
| ser_load | output | 1 | Chain latch strobe |
| ser_clk | output | 1 | Shared serial clock |
| dat_left | output | 1 | Left chain serial data |
| dat_right | output | 1 | Right chain serial data |

## Verification
The bench builds the block with three right pads and two left pads. `HOLD_MASK` marks one 12-bit pad on each side, so the chains total 38 and 25 bits. This small setup brings every boundary into a short run: the step from one pad to the next in both walking directions, the dropped most significant bit of a short pad, and thirteen cycles in which the left line holds zero while the right chain is still shifting. A receiving model in the bench captures both data lines on each rising serial clock and compares them bit by bit with the streams worked out from the word table.

// File: rtl/padcfg_pkg.sv
// Shared definitions for the pad configuration serializer.
// Assumes the control register bits 1..6 map one-to-one onto the line set below.
package padcfg_pkg;

    // Fixed positions in the control register (software decodes them).
    localparam int CTL_START = 0;
    localparam int CTL_LO    = 1;
    localparam int CTL_HI    = 6;

    // Line bundle, packed so that bits [6:1] of the register cast onto it.
    typedef struct packed {
        logic dat_left;
        logic dat_right;
        logic sclk;
        logic load;
        logic rstn;
        logic en;
    } line_set_t;

    // Sequencer phases.
    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_LOW   = 3'd1,
        SEQ_HIGH  = 3'd2,
        SEQ_LOAD1 = 3'd3,
        SEQ_LOAD2 = 3'd4
    } seq_state_t;

endpackage

// File: rtl/padcfg_ctrl_reg.sv
// Control register: holds the start bit and the six bit-bang lines.
// Assumes busy comes from the sequencer; writes during busy are dropped.
module padcfg_ctrl_reg
    import padcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       busy,
    input  logic       done_pulse,
    output line_set_t  lines,
    output logic       start_bit
);

    // Register update: reset, completion clear, or idle write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines     <= '0;
            start_bit <= 1'b0;
        end else if (done_pulse) begin
            start_bit <= 1'b0;
        end else if (wr_en && !busy) begin
            lines     <= line_set_t'(wr_data[CTL_HI:CTL_LO]);
            start_bit <= wr_data[CTL_START];
        end
    end

endmodule

// File: rtl/padcfg_chain_walker.sv
// Walks one chain pad by pad, presenting one word bit per shift pulse.
// Assumes FIRST and LAST are inside [0, N_PADS) and that ASCEND matches their order.
// A pad marked in HOLD_MASK skips the top word bit (12 of 13 bits).
module padcfg_chain_walker #(
    parameter int                     N_PADS    = 38,
    parameter int                     WORD_W    = 13,
    parameter int                     FIRST     = 0,
    parameter int                     LAST      = 18,
    parameter bit                     ASCEND    = 1'b1,
    parameter logic [N_PADS-1:0]      HOLD_MASK = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       advance,
    input  logic [N_PADS*WORD_W-1:0]   cfg_words,
    output logic                       bit_out,
    output logic                       done
);

    localparam int FLAT_W = N_PADS * WORD_W;
    localparam int IDX_W  = (N_PADS > 1) ? $clog2(N_PADS) : 1;
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int SEL_W  = $clog2(FLAT_W);

    logic [IDX_W-1:0] pad_idx;
    logic [IDX_W-1:0] pad_next;
    logic [BIT_W-1:0] bit_idx;
    logic [SEL_W-1:0] sel;

    // Highest bit index sent for a pad.
    function automatic logic [BIT_W-1:0] top_bit(input logic [IDX_W-1:0] p);
        return HOLD_MASK[p] ? BIT_W'(WORD_W - 2) : BIT_W'(WORD_W - 1);
    endfunction

    // Direction variant chosen by parameter.
    generate
        if (ASCEND) begin : g_up
            assign pad_next = pad_idx + IDX_W'(1);
        end else begin : g_down
            assign pad_next = pad_idx - IDX_W'(1);
        end
    endgenerate

    // Position counters: load on start, step on each shift pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_idx <= '0;
            bit_idx <= '0;
            done    <= 1'b1;
        end else if (start) begin
            pad_idx <= IDX_W'(FIRST);
            bit_idx <= top_bit(IDX_W'(FIRST));
            done    <= 1'b0;
        end else if (advance && !done) begin
            if (bit_idx == '0) begin
                if (pad_idx == IDX_W'(LAST)) begin
                    done <= 1'b1;
                end else begin
                    pad_idx <= pad_next;
                    bit_idx <= top_bit(pad_next);
                end
            end else begin
                bit_idx <= bit_idx - BIT_W'(1);
            end
        end
    end

    // Bit select into the flat word vector; zero once the chain is finished.
    always_comb begin
        sel     = SEL_W'(pad_idx) * SEL_W'(WORD_W) + SEL_W'(bit_idx);
        bit_out = done ? 1'b0 : cfg_words[sel];
    end

endmodule

// File: rtl/padcfg_sequencer.sv
// Phase engine for the automatic transfer: low/high shift phases, then a load window.
// Assumes both walkers report done only after their last bit has been clocked.
module padcfg_sequencer
    import padcfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic both_done,
    output logic walk_start,
    output logic advance,
    output logic busy,
    output logic sclk_auto,
    output logic load_auto,
    output logic done_pulse
);

    seq_state_t state;

    // Phase transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            case (state)
                SEQ_IDLE:  if (start_req) state <= SEQ_LOW;
                SEQ_LOW:   state <= both_done ? SEQ_LOAD1 : SEQ_HIGH;
                SEQ_HIGH:  state <= SEQ_LOW;
                SEQ_LOAD1: state <= SEQ_LOAD2;
                SEQ_LOAD2: state <= SEQ_IDLE;
                default:   state <= SEQ_IDLE;
            endcase
        end
    end

    // Phase decode into strobes and line levels.
    always_comb begin
        busy       = (state != SEQ_IDLE);
        walk_start = (state == SEQ_IDLE) && start_req;
        advance    = (state == SEQ_HIGH);
        sclk_auto  = (state == SEQ_HIGH);
        load_auto  = (state == SEQ_LOAD1) || (state == SEQ_LOAD2);
        done_pulse = (state == SEQ_LOAD2);
    end

endmodule

// File: rtl/padcfg_serializer.sv
// Top: control register, sequencer and two chain walkers, plus the output mux
// choosing between automatic drive and the bit-bang register lines.
// Assumes N_RIGHT >= 1 and N_LEFT >= 1; right pads are the low indices.
module padcfg_serializer
    import padcfg_pkg::*;
#(
    parameter int                              N_RIGHT   = 19,
    parameter int                              N_LEFT    = 19,
    parameter int                              WORD_W    = 13,
    parameter logic [N_RIGHT+N_LEFT-1:0]       HOLD_MASK = '0
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [7:0]                          wr_data,
    input  logic [(N_RIGHT+N_LEFT)*WORD_W-1:0]  cfg_words,
    output logic [7:0]                          rd_data,
    output logic                                busy,
    output logic                                ser_en,
    output logic                                ser_rstn,
    output logic                                ser_load,
    output logic                                ser_clk,
    output logic                                dat_left,
    output logic                                dat_right
);

    localparam int N_PADS = N_RIGHT + N_LEFT;

    line_set_t lines;
    logic      start_bit;
    logic      start_req;
    logic      walk_start, advance, sclk_auto, load_auto, done_pulse;
    logic      bit_r, bit_l, done_r, done_l;

    // Start request: a write with the start bit set while idle.
    assign start_req = wr_en && wr_data[CTL_START] && !busy;

    padcfg_ctrl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .busy       (busy),
        .done_pulse (done_pulse),
        .lines      (lines),
        .start_bit  (start_bit)
    );

    padcfg_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .both_done  (done_r && done_l),
        .walk_start (walk_start),
        .advance    (advance),
        .busy       (busy),
        .sclk_auto  (sclk_auto),
        .load_auto  (load_auto),
        .done_pulse (done_pulse)
    );

    // Right chain: farthest pad is N_RIGHT-1, walking down to pad 0.
    padcfg_chain_walker #(
        .N_PADS    (N_PADS),
        .WORD_W    (WORD_W),
        .FIRST     (N_RIGHT - 1),
        .LAST      (0),
        .ASCEND    (1'b0),
        .HOLD_MASK (HOLD_MASK)
    ) u_walk_r (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (walk_start),
        .advance   (advance),
        .cfg_words (cfg_words),
        .bit_out   (bit_r),
        .done      (done_r)
    );

    // Left chain: farthest pad is N_RIGHT, walking up to the top pad.
    padcfg_chain_walker #(
        .N_PADS    (N_PADS),
        .WORD_W    (WORD_W),
        .FIRST     (N_RIGHT),
        .LAST      (N_PADS - 1),
        .ASCEND    (1'b1),
        .HOLD_MASK (HOLD_MASK)
    ) u_walk_l (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (walk_start),
        .advance   (advance),
        .cfg_words (cfg_words),
        .bit_out   (bit_l),
        .done      (done_l)
    );

    // Output mux: the engine owns the lines while busy, the register otherwise.
    always_comb begin
        rd_data   = {1'b0, lines, start_bit};
        ser_en    = busy ? 1'b1      : lines.en;
        ser_rstn  = busy ? 1'b1      : lines.rstn;
        ser_load  = busy ? load_auto : lines.load;
        ser_clk   = busy ? sclk_auto : lines.sclk;
        dat_right = busy ? bit_r     : lines.dat_right;
        dat_left  = busy ? bit_l     : lines.dat_left;
    end

endmodule

// File: rtl/padcfg_serializer_chk.sv
// Port-level checker for padcfg_serializer, attached with bind.
module padcfg_serializer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       busy,
    input logic       ser_en,
    input logic       ser_rstn,
    input logic       ser_load,
    input logic       ser_clk,
    input logic       dat_left,
    input logic       dat_right
);

    // Top bit of the read value never set.
    assert_top_bit_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] == 1'b0);

    // Idle write reaches the lines on the following cycle.
    assert_bitbang_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && !wr_data[0]) |=>
            (ser_clk == $past(wr_data[4]) && ser_en == $past(wr_data[1]) &&
             dat_left == $past(wr_data[6])));

    // Engine keeps the chains enabled and out of reset.
    assert_busy_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ser_en && ser_rstn));

    // Data steady across each rising serial clock.
    assert_data_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $rose(ser_clk)) |-> ($stable(dat_left) && $stable(dat_right)));

    // No clocking during the load window.
    assert_load_clock_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ser_load) |-> !ser_clk);

    // Start bit cleared when the transfer ends.
    assert_start_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !rd_data[0]);

    // Register bits frozen during a transfer.
    assert_busy_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rd_data[6:1]));

endmodule

bind padcfg_serializer padcfg_serializer_chk u_chk (.*);

// File: tb/padcfg_serializer_bench.sv
`timescale 1ns/1ps
module padcfg_serializer_bench;

    localparam int NR = 3;
    localparam int NL = 2;
    localparam int NP = NR + NL;
    localparam int WW = 13;
    localparam logic [NP-1:0] HM = 5'b01010;
    localparam int NVEC = 4;
    // Word table: pad 0 in the lowest 13 bits.
    localparam logic [NP*WW-1:0] VEC [NVEC] = '{
        65'h1FFFFFFFFFFFFFFFF,
        65'h0AAAA5555AAAA5555,
        65'h123456789ABCDEF01,
        65'h00008000002000000   // only the dropped bits 12 of pads 1 and 3
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [NP*WW-1:0] cfg_words = '0;
    logic [7:0] rd_data;
    logic busy, ser_en, ser_rstn, ser_load, ser_clk, dat_left, dat_right;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    padcfg_serializer #(.N_RIGHT(NR), .N_LEFT(NL), .WORD_W(WW), .HOLD_MASK(HM)) u_padcfg_serializer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cfg_words(cfg_words),
        .rd_data(rd_data), .busy(busy), .ser_en(ser_en), .ser_rstn(ser_rstn),
        .ser_load(ser_load), .ser_clk(ser_clk), .dat_left(dat_left), .dat_right(dat_right));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int pad_len(input int p);
        return HM[p] ? WW - 1 : WW;
    endfunction

    // One automatic transfer with a receiving model on both chains.
    task automatic run_transfer(input logic [NP*WW-1:0] words, input bit inject);
        logic got_r [64];
        logic got_l [64];
        logic exp_r [64];
        logic exp_l [64];
        int n_r = 0, n_l = 0, pulses = 0, load_cnt = 0, cyc = 0;
        bit prev_clk = 1'b0, clk_after_load = 1'b0, en_bad = 1'b0;
        int mis_r = 0, mis_l = 0, exp_pulses;
        for (int i = 0; i < 64; i++) begin
            exp_r[i] = 1'b0; exp_l[i] = 1'b0; got_r[i] = 1'b0; got_l[i] = 1'b0;
        end
        // Expected streams (R6): right downward from NR-1, left upward from NR, MSB first.
        for (int p = NR - 1; p >= 0; p--)
            for (int b = pad_len(p) - 1; b >= 0; b--) begin
                exp_r[n_r] = words[p*WW + b]; n_r++;
            end
        for (int p = NR; p < NP; p++)
            for (int b = pad_len(p) - 1; b >= 0; b--) begin
                exp_l[n_l] = words[p*WW + b]; n_l++;
            end
        exp_pulses = (n_r > n_l) ? n_r : n_l;

        @(negedge clk);
        cfg_words = words;
        wr_en = 1'b1;
        wr_data = 8'h07;
        do begin
            @(negedge clk);
            wr_en = 1'b0;
            cyc++;
            if (ser_clk && !prev_clk) begin
                if (pulses < 64) begin
                    got_r[pulses] = dat_right;
                    got_l[pulses] = dat_left;
                end
                pulses++;
                if (load_cnt > 0) clk_after_load = 1'b1;
            end
            prev_clk = ser_clk;
            if (busy && ser_load) load_cnt++;
            if (busy && (!ser_en || !ser_rstn)) en_bad = 1'b1;
            if (inject && cyc == 9) begin
                wr_en = 1'b1;
                wr_data = 8'h78;
            end
        end while (busy && cyc < 2000);

        check(pulses == exp_pulses, "R5 pulse count", pulses, exp_pulses);
        for (int i = 0; i < exp_pulses; i++) begin
            if (got_r[i] !== exp_r[i]) mis_r++;
            if (got_l[i] !== exp_l[i]) mis_l++;
        end
        check(mis_r == 0, "R6 right stream bit errors", mis_r, 0);
        check(mis_l == 0, "R6/R7 left stream bit errors (zero fill included)", mis_l, 0);
        check(load_cnt == 2 && !clk_after_load, "R9 load window cycles", load_cnt, 2);
        check(!en_bad, "R4 enable/reset held during transfer", int'(en_bad), 0);
        check(rd_data == 8'h06, inject ? "R10 register after ignored write" : "R9 start bit cleared",
              rd_data, 8'h06);
        check(!ser_clk && ser_en && ser_rstn && !ser_load, "R9 lines back to register",
              {ser_load, ser_clk, ser_rstn, ser_en}, 4'b0011);
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        check(rd_data == 8'h00, "R2 register after reset", rd_data, 0);
        check(!busy && !ser_en && !ser_rstn && !ser_load && !ser_clk, "R2 lines after reset",
              {busy, ser_en, ser_rstn, ser_load, ser_clk}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 bit-bang pattern table: write value, expected read, expected lines {dl,dr,clk,load,rstn,en}.
        write_reg(8'h7E);
        check(rd_data == 8'h7E, "R1 readback all lines", rd_data, 8'h7E);
        check({dat_left, dat_right, ser_clk, ser_load, ser_rstn, ser_en} == 6'b111111,
              "R3 all lines high", {dat_left, dat_right, ser_clk, ser_load, ser_rstn, ser_en}, 6'h3F);
        write_reg(8'h2A);
        check({dat_left, dat_right, ser_clk, ser_load, ser_rstn, ser_en} == 6'b010101,
              "R3 alternating lines", {dat_left, dat_right, ser_clk, ser_load, ser_rstn, ser_en}, 6'h15);
        write_reg(8'hD4);
        check(rd_data == 8'h54, "R1 bit 7 reads zero", rd_data, 8'h54);
        check({dat_left, dat_right, ser_clk, ser_load, ser_rstn, ser_en} == 6'b101010,
              "R3 other lines", {dat_left, dat_right, ser_clk, ser_load, ser_rstn, ser_en}, 6'h2A);
        check(!busy, "R3 no transfer without bit 0", busy, 0);

        // Automatic transfers over the word table; vector 2 carries a write during busy (R10).
        for (int v = 0; v < NVEC; v++) run_transfer(VEC[v], v == 2);

        // R4 busy right after start, then R2 reset during a transfer.
        write_reg(8'h07);
        check(busy && rd_data[0], "R4 busy and start bit after start", {busy, rd_data[0]}, 2'b11);
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && rd_data == 8'h00 && !ser_rstn && !ser_en, "R2 reset aborts transfer",
              {busy, rd_data, ser_rstn, ser_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule